// File: doc/BRIEF.md
# Trigger-Centred Sample Capture Buffer

This block records a probe bus into a circular memory on every clock while it is armed. The newest sample always replaces the oldest one. A single trigger bit marks the event of interest, such as an error or a failed check. Two depths are loaded when the block is armed:

- how many samples of history to keep from before the trigger;
- how many samples to take from the trigger onward.

Once the post-trigger samples are stored, writing stops and the window is frozen.

A stop input freezes capture at once, without waiting for a trigger. The frozen window can then be read through an index port. Index zero is the oldest valid sample, and data appears one clock after the index is presented. Status outputs report:

- that capture is frozen;
- how many samples are valid;
- whether a trigger was seen;
- where the trigger sample sits in the window;
- whether the history before it was shorter than requested.

The run-time depths must sum to no more than the memory depth.

Top module: `trig_capture`

## Requirements
- R1: After reset the block is idle: `done`, `triggered` and `partial` are 0, `valid_count` is 0 and nothing is written. A one-cycle `arm` pulse loads `pre_depth` and `post_depth`, clears all counts and flags, and starts capture on the following clock. `arm` takes priority over every other input.
- R2: While armed and not yet triggered, one probe sample is stored per clock. `valid_count` grows by one per clock but never exceeds the loaded pre depth, so only the most recent pre-depth samples belong to the window.
- R3: A trigger while armed, with post depth P ≥ 1, stores the probe sample of the trigger clock as the first post sample. Exactly P samples are stored counting that one. `done` rises after the clock that stores the P-th sample and is 0 before it.
- R4: With `done` high, `rd_data` holds, one clock after `rd_idx` is presented, the window sample at position `rd_idx`. Position 0 is the oldest valid sample, and positions increase in capture order up to `valid_count`−1.
- R5: A `stop` while armed or while post-trigger sampling freezes capture on that clock, and the sample of that clock is not stored. A stop before any trigger leaves `triggered` at 0. A stop during post sampling keeps the post samples already stored.
- R6: A trigger is ignored outside the armed pre-trigger state: when idle, during post sampling and when frozen. It changes neither `done` nor `valid_count`.
- R7: `partial` is set to 1 when a trigger arrives while fewer than pre-depth samples have been stored since arming; otherwise it is 0.
- R8: `trig_index` equals the number of pre-trigger samples in the window, which is the position of the trigger sample. The final `valid_count` of a triggered capture is that number plus the post samples stored.
- R9: While `done` is high, no memory write occurs, so further probe activity leaves the frozen window unchanged.
- R10: With post depth 0, a trigger freezes capture on the trigger clock without storing that clock's sample. `triggered` becomes 1 and `trig_index` equals `valid_count`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| arm | input | 1 | Clear state, load depths, start capture |
| pre_depth | input | AW+1 | Samples to keep before the trigger |
| post_depth | input | AW+1 | Samples to keep from the trigger on |
| probe | input | DATA_W | Sampled bus |
| trigger | input | 1 | Trigger event pulse |
| stop | input | 1 | Manual freeze request |
| rd_idx | input | AW | Window position to read, 0 = oldest |
| rd_data | output | DATA_W | Sample at the requested position (1-clock latency) |
| done | output | 1 | Capture is frozen |
| triggered | output | 1 | A trigger was accepted |
| partial | output | 1 | Pre-trigger history was short |
| valid_count | output | AW+1 | Number of valid window samples |
| trig_index | output | AW+1 | Window position of the trigger sample |

## Verification
The bench builds the block with AW=4 (a 16-entry memory) and DATA_W=8. With that depth, back-to-back captures drive the write pointer through many wraps. A window of pre plus post equal to the full memory is also reachable, where the oldest valid sample sits exactly at the write pointer. The small depth also lets random pre/post splits, short and long histories, and stops at every phase be covered in a few thousand clocks. Directed runs cover a zero pre depth, a zero post depth, and a trigger before arming.

// File: rtl/trigcap_pkg.sv
package trigcap_pkg;
  typedef enum logic [1:0] {
    CAP_IDLE  = 2'd0,
    CAP_ARMED = 2'd1,
    CAP_POST  = 2'd2,
    CAP_DONE  = 2'd3
  } cap_state_t;
endpackage

// File: rtl/trigcap_mem.sv
module trigcap_mem #(
  parameter int DATA_W = 8,
  parameter int AW     = 4
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DATA_W-1:0] ram [DEPTH];

  always_ff @(posedge clk) begin
    if (we) ram[waddr] <= wdata;
    rdata <= ram[raddr];
  end
endmodule

// File: rtl/trigcap_ctrl.sv
module trigcap_ctrl
  import trigcap_pkg::*;
#(
  parameter int AW    = 4,
  parameter int CNT_W = AW + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             arm,
  input  logic [CNT_W-1:0] pre_in,
  input  logic [CNT_W-1:0] post_in,
  input  logic             trigger,
  input  logic             stop,
  output logic             wr_en,
  output logic [AW-1:0]    wr_ptr,
  output logic [CNT_W-1:0] valid_o,
  output logic [CNT_W-1:0] tidx_o,
  output logic             partial_o,
  output logic             hit_o,
  output logic             done_o
);
  cap_state_t       state;
  logic [CNT_W-1:0] pre_q, post_q, post_cnt;

  always_comb begin
    wr_en = 1'b0;
    if (!arm) begin
      if (state == CAP_ARMED)
        wr_en = !stop && !(trigger && post_q == '0);
      else if (state == CAP_POST)
        wr_en = !stop;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= CAP_IDLE;
      wr_ptr    <= '0;
      valid_o   <= '0;
      tidx_o    <= '0;
      partial_o <= 1'b0;
      hit_o     <= 1'b0;
      pre_q     <= '0;
      post_q    <= '0;
      post_cnt  <= '0;
    end else if (arm) begin
      state     <= CAP_ARMED;
      wr_ptr    <= '0;
      valid_o   <= '0;
      tidx_o    <= '0;
      partial_o <= 1'b0;
      hit_o     <= 1'b0;
      pre_q     <= pre_in;
      post_q    <= post_in;
      post_cnt  <= '0;
    end else begin
      case (state)
        CAP_ARMED: begin
          if (stop) begin
            state  <= CAP_DONE;
            tidx_o <= valid_o;
          end else if (trigger) begin
            hit_o     <= 1'b1;
            tidx_o    <= valid_o;
            partial_o <= (valid_o < pre_q);
            if (post_q == '0) begin
              state <= CAP_DONE;
            end else begin
              wr_ptr   <= wr_ptr + 1'b1;
              valid_o  <= valid_o + 1'b1;
              post_cnt <= CNT_W'(1);
              state    <= (post_q == CNT_W'(1)) ? CAP_DONE : CAP_POST;
            end
          end else begin
            wr_ptr <= wr_ptr + 1'b1;
            if (valid_o < pre_q) valid_o <= valid_o + 1'b1;
          end
        end
        CAP_POST: begin
          if (stop) begin
            state <= CAP_DONE;
          end else begin
            wr_ptr   <= wr_ptr + 1'b1;
            valid_o  <= valid_o + 1'b1;
            post_cnt <= post_cnt + 1'b1;
            if (post_cnt + CNT_W'(1) == post_q) state <= CAP_DONE;
          end
        end
        default: ;
      endcase
    end
  end

  assign done_o = (state == CAP_DONE);

  // R2: history never exceeds the loaded pre depth before the trigger
  a_r2_pre_bound: assert property (@(posedge clk) disable iff (rst)
    (state == CAP_ARMED) |-> (valid_o <= pre_q));

  // R3: post sampling never runs past the loaded post depth
  a_r3_post_bound: assert property (@(posedge clk) disable iff (rst)
    (state == CAP_POST) |-> (post_cnt < post_q));

  // R5: a stop while capturing freezes on the next clock
  a_r5_stop_freezes: assert property (@(posedge clk) disable iff (rst)
    ((state == CAP_ARMED || state == CAP_POST) && stop && !arm) |=> done_o);

  // R6: a trigger while idle does not start anything
  a_r6_idle_ignores: assert property (@(posedge clk) disable iff (rst)
    (state == CAP_IDLE && !arm) |=> (state == CAP_IDLE));

  // R9: the frozen window keeps its pointer and count
  a_r9_frozen_stable: assert property (@(posedge clk) disable iff (rst)
    (done_o && !arm) |=> ($stable(wr_ptr) && $stable(valid_o)));
endmodule

// File: rtl/trig_capture.sv
module trig_capture #(
  parameter int DATA_W = 8,
  parameter int AW     = 4,
  localparam int CNT_W = AW + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              arm,
  input  logic [CNT_W-1:0]  pre_depth,
  input  logic [CNT_W-1:0]  post_depth,
  input  logic [DATA_W-1:0] probe,
  input  logic              trigger,
  input  logic              stop,
  input  logic [AW-1:0]     rd_idx,
  output logic [DATA_W-1:0] rd_data,
  output logic              done,
  output logic              triggered,
  output logic              partial,
  output logic [CNT_W-1:0]  valid_count,
  output logic [CNT_W-1:0]  trig_index
);
  logic          mem_we;
  logic [AW-1:0] wp;
  logic [AW-1:0] rd_addr;

  trigcap_ctrl #(.AW(AW), .CNT_W(CNT_W)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .arm      (arm),
    .pre_in   (pre_depth),
    .post_in  (post_depth),
    .trigger  (trigger),
    .stop     (stop),
    .wr_en    (mem_we),
    .wr_ptr   (wp),
    .valid_o  (valid_count),
    .tidx_o   (trig_index),
    .partial_o(partial),
    .hit_o    (triggered),
    .done_o   (done)
  );

  // oldest valid sample sits valid_count entries behind the write pointer
  assign rd_addr = wp - valid_count[AW-1:0] + rd_idx;

  trigcap_mem #(.DATA_W(DATA_W), .AW(AW)) u_mem (
    .clk  (clk),
    .we   (mem_we),
    .waddr(wp),
    .wdata(probe),
    .raddr(rd_addr),
    .rdata(rd_data)
  );

  // R9: no memory write while frozen
  a_r9_no_write_frozen: assert property (@(posedge clk) disable iff (rst)
    done |-> !mem_we);

  // R8: trigger position never lies beyond the valid window
  a_r8_index_in_window: assert property (@(posedge clk) disable iff (rst)
    (done && triggered) |-> (trig_index <= valid_count));
endmodule

// File: tb/trig_capture_test.sv
module trig_capture_test;
  localparam int DW = 8;
  localparam int AW = 4;
  localparam int CW = AW + 1;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic arm = 1'b0;
  logic [CW-1:0] pre_depth = '0, post_depth = '0;
  logic [DW-1:0] probe = '0;
  logic trigger = 1'b0, stop = 1'b0;
  logic [AW-1:0] rd_idx = '0;
  logic [DW-1:0] rd_data;
  logic done, triggered, partial;
  logic [CW-1:0] valid_count, trig_index;

  int n_chk = 0;
  int n_fail = 0;
  logic [DW-1:0] hist [0:63];
  logic [DW-1:0] postv [0:31];
  logic [DW-1:0] win [0:31];

  always #2.5 clk = ~clk;

  trig_capture #(.DATA_W(DW), .AW(AW)) uut (
    .clk(clk), .rst(rst), .arm(arm), .pre_depth(pre_depth),
    .post_depth(post_depth), .probe(probe), .trigger(trigger), .stop(stop),
    .rd_idx(rd_idx), .rd_data(rd_data), .done(done), .triggered(triggered),
    .partial(partial), .valid_count(valid_count), .trig_index(trig_index)
  );

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // mode 0: trigger and full post; mode 1: stop before trigger;
  // mode 2: trigger, then stop after k post samples (1 <= k < post)
  task automatic run_cap(int pre, int post, int nb, int mode, int k);
    int pv, npost, vexp;
    @(negedge clk);
    pre_depth = CW'(pre); post_depth = CW'(post); arm = 1'b1;
    @(negedge clk);
    arm = 1'b0;
    for (int i = 0; i < nb; i++) begin
      probe = DW'($urandom); hist[i] = probe;
      @(negedge clk);
    end
    pv = (nb < pre) ? nb : pre;
    npost = 0;
    if (mode == 1) begin
      probe = DW'($urandom); stop = 1'b1;
      @(negedge clk);
      stop = 1'b0;
    end else begin
      probe = DW'($urandom); trigger = 1'b1; postv[0] = probe;
      @(negedge clk);
      trigger = 1'b0;
      npost = (post == 0) ? 0 : 1;
      for (int j = 1; j < ((mode == 2) ? k : post); j++) begin
        chk("R3 done low during post", int'(done), 0);
        probe = DW'($urandom); postv[j] = probe;
        trigger = (j == 1); // R6: retrigger during post ignored
        @(negedge clk);
        trigger = 1'b0;
        npost++;
      end
      if (mode == 2) begin
        probe = DW'($urandom); stop = 1'b1;
        @(negedge clk);
        stop = 1'b0;
      end
    end
    vexp = pv + npost;
    chk("R3/R5 done", int'(done), 1);
    chk("R8 valid_count", int'(valid_count), vexp);
    chk("R5/R10 triggered", int'(triggered), (mode == 1) ? 0 : 1);
    if (mode != 1) begin
      chk("R7 partial", int'(partial), (nb < pre) ? 1 : 0);
      chk("R8 trig_index", int'(trig_index), pv);
    end
    if (post == 0 && mode == 0)
      chk("R10 index equals count", int'(trig_index), int'(valid_count));
    for (int i = 0; i < pv; i++) win[i] = hist[nb - pv + i];
    for (int j = 0; j < npost; j++) win[pv + j] = postv[j];
    // R6/R9: keep probing and triggering while frozen
    for (int i = 0; i < 3; i++) begin
      probe = DW'($urandom); trigger = 1'b1;
      @(negedge clk);
    end
    trigger = 1'b0;
    chk("R6 frozen trigger ignored", int'(valid_count), vexp);
    for (int i = 0; i < vexp; i++) begin
      rd_idx = AW'(i);
      @(negedge clk);
      chk("R4/R9 window sample", int'(rd_data), int'(win[i]));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    int pre, post, nb, mode, k;
    void'($urandom(32'd5150));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1 reset done", int'(done), 0);
    chk("R1 reset valid", int'(valid_count), 0);
    chk("R1 reset triggered", int'(triggered), 0);
    // R6: trigger while idle
    trigger = 1'b1;
    repeat (2) @(negedge clk);
    trigger = 1'b0;
    chk("R6 idle trigger done", int'(done), 0);
    chk("R6 idle trigger valid", int'(valid_count), 0);
    // directed corners
    run_cap(8, 4, 20, 0, 0);          // R2 history wraps past pre
    run_cap(8, 4, 3, 0, 0);           // R7 short history
    run_cap(0, DEPTH, 5, 0, 0);       // no pre history, full post
    run_cap(DEPTH, 0, 30, 0, 0);      // R10 zero post, full memory
    run_cap(10, 6, 25, 0, 0);         // window equals memory depth
    run_cap(6, 5, 9, 1, 0);           // R5 stop before trigger
    run_cap(5, 8, 12, 2, 3);          // R5 stop during post
    // R1: arm mid-capture restarts
    @(negedge clk);
    pre_depth = CW'(4); post_depth = CW'(2); arm = 1'b1;
    @(negedge clk);
    arm = 1'b0;
    repeat (3) @(negedge clk);
    arm = 1'b1;
    @(negedge clk);
    arm = 1'b0;
    chk("R1 rearm clears count", int'(valid_count), 0);
    chk("R1 rearm clears done", int'(done), 0);
    // random captures
    for (int r = 0; r < 40; r++) begin
      pre  = $urandom % (DEPTH + 1);
      post = $urandom % (DEPTH - pre + 1);
      nb   = $urandom % 24;
      mode = $urandom % 3;
      if (mode == 2 && post < 2) mode = 0;
      k = (mode == 2) ? 1 + ($urandom % (post - 1)) : 0;
      run_cap(pre, post, nb, mode, k);
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule